// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a microcontroller's transmit line and the low-side driver enable of a single-wire LIN physical layer. It passes a dominant command to the driver only while the node is in normal mode, the guard is armed, and the synchronized transmit line is low. A high transmit line leaves the driver off, so the bus stays recessive.

The guard qualifies the line in two ways. The first is re-arming. On every entry into normal mode, and after every timeout, the driver stays disabled until transmit has been high for a minimum run of microsecond ticks. A low level that is already present when the mode is entered therefore never reaches the bus. The second is timeout. While armed, a low run that lasts the full timeout forces the bus recessive, drops the armed state and sets a sticky fault flag.

The fault flag clears on the same edge that the next re-arm completes. A build-time parameter removes the timeout, so a static low can be held on the bus indefinitely, but the re-arm rule stays in force. Both intervals are counted in 1 µs ticks supplied beside the clock. A transmit input that is floating or in reset is taken as low.

Top module: `txd_dom_guard`

## Requirements
- R1: `drv_on` is 1 only when `normal_mode` is 1, the guard is armed and the synchronized transmit level is low. It is 0 whenever the synchronized level is high.
- R2: `txd_in` passes through two flip-flops, so a change on it reaches `drv_on` after the second rising clock edge and not after the first.
- R3: After `normal_mode` rises, and with the synchronizer cleared while reset is applied, the guard arms only after the synchronized transmit has been high on `REARM_TICKS` consecutive tick cycles. Until then `drv_on` stays 0, even if `txd_in` is low at mode entry.
- R4: A high run shorter than `REARM_TICKS` ticks that is ended by a low level does not arm the guard. The next high run starts counting from zero.
- R5: While armed (with `HAS_TIMEOUT`=1), a synchronized low run lasting `TIMEOUT_TICKS` tick cycles disarms the guard on that edge, so `drv_on` goes to 0 and `fault` goes to 1.
- R6: `fault` stays 1 through short high runs and mode changes. It returns to 0 on the same edge at which the re-arm condition of R3 completes.
- R7: With `HAS_TIMEOUT`=0, a low run of any length keeps `drv_on` at 1 and `fault` at 0, while R3 and R4 still apply.
- R8: While `normal_mode` is 0, `drv_on` is 0 in the same cycle. The armed state and the counter are cleared, so the R3 qualification is required again on the next entry.
- R9: Counting advances only on cycles with `us_tick` = 1. Without ticks, neither arming nor timeout happens, and the counter saturates instead of wrapping.
- R10: After reset, `drv_on` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| normal_mode | input | 1 | 1 while the node is in normal mode |
| txd_in | input | 1 | Asynchronous transmit line from the controller, low = dominant |
| drv_on | output | 1 | Bus driver enable, 1 = drive dominant |
| fault | output | 1 | Sticky dominant-timeout fault |

## Verification
A wrong armed bit shows up at `drv_on` as soon as transmit is driven low: two clocks later the driver is either on when it should be blocked or blocked when it should follow. Tests sweep the high-run length around `REARM_TICKS` to expose this. A wrong counter shows up as a `fault` edge, and the reopening of the driver, landing one or more tick cycles away from the expected position. The bench therefore checks every cycle across the timeout boundary and across the re-arm boundary after a fault. A fault flag that is lost or stuck is visible directly at `fault`, including across a mode exit.

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int unsigned TIMEOUT_TICKS = 60000,
  parameter int unsigned REARM_TICKS   = 11,
  parameter bit          HAS_TIMEOUT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic normal_mode,
  input  logic txd_in,
  output logic drv_on,
  output logic fault
);
  localparam int unsigned CMAX = (TIMEOUT_TICKS > REARM_TICKS) ? TIMEOUT_TICKS : REARM_TICKS;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] REARM_LAST = CW'(REARM_TICKS - 1);
  localparam logic [CW-1:0] TO_LAST    = CW'(TIMEOUT_TICKS - 1);
  localparam logic [CW-1:0] SAT        = CW'(CMAX);

  logic          s1, s2, armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2} <= 2'b00;
    else        {s1, s2} <= {txd_in, s1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      fault <= 1'b0;
    end else if (!normal_mode) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!armed) begin
      if (!s2) cnt <= '0;
      else if (us_tick) begin
        if (cnt == REARM_LAST) begin
          armed <= 1'b1;
          cnt   <= '0;
          fault <= 1'b0;
        end else cnt <= cnt + 1'b1;
      end
    end else begin
      if (s2) cnt <= '0;
      else if (us_tick) begin
        if (HAS_TIMEOUT && cnt == TO_LAST) begin
          armed <= 1'b0;
          cnt   <= '0;
          fault <= 1'b1;
        end else if (cnt != SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  assign drv_on = normal_mode & armed & ~s2;

  p_drv_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_on |-> !$past(txd_in, 2));
  p_arm_needs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(s2) && $past(normal_mode));
  p_fault_cuts_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(drv_on) && !drv_on);
  p_fault_clear_on_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> armed && !$past(armed));
  p_idle_outside_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_mode |=> !armed && cnt == '0);
  p_no_tick_no_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !us_tick |=> !$rose(armed) && !$rose(fault));
  p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT);

  if (!HAS_TIMEOUT) begin : g_nt
    p_never_fault_r7: assert property (@(posedge clk) disable iff (!rst_n) !fault);
  end
endmodule

// File: tb/test_txd_dom_guard.sv
module test_txd_dom_guard;
  localparam int unsigned TO = 12;
  localparam int unsigned RA = 4;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b1, normal_mode = 1'b0, txd_in = 1'b0;
  logic drv_on, fault, drv_nt, fault_nt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txd_dom_guard #(.TIMEOUT_TICKS(TO), .REARM_TICKS(RA), .HAS_TIMEOUT(1'b1)) i_txd_dom_guard (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .normal_mode(normal_mode),
    .txd_in(txd_in), .drv_on(drv_on), .fault(fault));
  txd_dom_guard #(.TIMEOUT_TICKS(TO), .REARM_TICKS(RA), .HAS_TIMEOUT(1'b0)) i_txd_dom_guard_nt (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .normal_mode(normal_mode),
    .txd_in(txd_in), .drv_on(drv_nt), .fault(fault_nt));

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic enter_normal();
    normal_mode = 1'b0; txd_in = 1'b0; cyc(2);
    normal_mode = 1'b1; cyc(3);
  endtask

  initial begin
    cyc(3);
    chk("R10 drv", drv_on, 1'b0);
    chk("R10 fault", fault, 1'b0);
    rst_n = 1'b1; cyc(2);

    // R3/R4 sweep of high-run length around the re-arm count
    for (int n = 0; n <= int'(RA) + 3; n++) begin
      enter_normal();
      chk("R3 low at entry", drv_on, 1'b0);
      txd_in = 1'b1; cyc(n);
      chk("R1 high keeps off", drv_on, 1'b0);
      txd_in = 1'b0; cyc(3);
      chk("R4 arm vs run", drv_on, logic'(n >= int'(RA)));
      chk("R4 arm vs run nt", drv_nt, logic'(n >= int'(RA)));
    end

    // R4: broken run restarts
    enter_normal();
    txd_in = 1'b1; cyc(RA - 1); txd_in = 1'b0; cyc(1);
    txd_in = 1'b1; cyc(RA - 1); txd_in = 1'b0; cyc(3);
    chk("R4 restart", drv_on, 1'b0);

    // R2 latency and R5 timeout sweep
    enter_normal();
    txd_in = 1'b1; cyc(RA + 2);
    txd_in = 1'b0; cyc(1);
    chk("R2 one edge", drv_on, 1'b0);
    for (int k = 2; k <= int'(TO) + 5; k++) begin
      cyc(1);
      chk("R5 drv", drv_on, logic'(k < int'(TO) + 2));
      chk("R5 fault", fault, logic'(k >= int'(TO) + 2));
      chk("R7 nt drv", drv_nt, 1'b1);
      chk("R7 nt fault", fault_nt, 1'b0);
    end
    cyc(3 * TO);
    chk("R7 nt long low", drv_nt, 1'b1);
    chk("R5 stays off", drv_on, 1'b0);

    // R6: short run keeps fault; mode exit keeps fault
    txd_in = 1'b1; cyc(RA - 1); txd_in = 1'b0; cyc(3);
    chk("R6 short run", fault, 1'b1);
    chk("R6 short run drv", drv_on, 1'b0);
    normal_mode = 1'b0; #0.5;
    chk("R8 nt off now", drv_nt, 1'b0);
    cyc(2);
    chk("R6 fault held", fault, 1'b1);
    normal_mode = 1'b1; cyc(3);
    chk("R8 requalify nt", drv_nt, 1'b0);
    txd_in = 1'b1;
    for (int k = 1; k <= int'(RA) + 3; k++) begin
      cyc(1);
      chk("R6 clear edge", fault, logic'(k < int'(RA) + 2));
    end
    txd_in = 1'b0; cyc(3);
    chk("R6 drive back", drv_on, 1'b1);

    // R9: no ticks, no arming and no timeout
    enter_normal();
    us_tick = 1'b0;
    txd_in = 1'b1; cyc(3 * RA); txd_in = 1'b0; cyc(3);
    chk("R9 no arm", drv_on, 1'b0);
    us_tick = 1'b1;
    txd_in = 1'b1; cyc(RA + 2); txd_in = 1'b0; cyc(3);
    us_tick = 1'b0; cyc(3 * TO);
    chk("R9 no timeout", fault, 1'b0);
    chk("R9 still drive", drv_on, 1'b1);
    us_tick = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule